// File: doc/BRIEF.md
# Single-Source Block-Pair Delay Feeder

This front end sits ahead of a transform engine that consumes two sample lanes at once, called the real lane and the imaginary lane. In the single-source modes it takes one continuous sample stream, passes every accepted sample straight to the imaginary lane, and writes the same sample into a delay line one block long. The delay line replays each block on the real lane exactly one block later. The engine therefore sees block n on the real lane and block n+1 on the imaginary lane in the same beats.

Because both lanes run as a continuous skewed stream, overlapped pairs are already present in it: a pair window that opens half a block later holds blocks 1.5 and 2.5. The block marks the first beat of each pair window that the engine should take. The order of windows is (1,2), then the overlapped windows, then (3,4), and so on.

In the dual-source modes the two input buses drive the two lanes directly, with no delay. The windows then repeat every hop over the common stream. A 3-bit mode input selects the source arrangement and the overlap, and the code 000 is treated as a configuration error.

Top module: `bpf_top`

## Requirements
- R1: While reset is active, `re_vld_o`, `im_vld_o`, `win_start_o` and `cfg_err_o` are all low.
- R2: Mode code 000 is invalid. One cycle after a cycle with mode 000, `cfg_err_o` is high and both lane valids are low. Under any other code, `cfg_err_o` is low one cycle later.
- R3: Single-source codes are 001, 010, 011 and 100, and the source is `in_re_i`. Once primed, an accepted sample appears on `im_data_o` one cycle later. In that same cycle `re_data_o` carries the sample accepted exactly BLK_LEN accepted samples earlier.
- R4: In the single-source codes, the first BLK_LEN samples accepted after a restart give no lane valid. Every accepted sample after that gives a lane beat.
- R5: Dual-source codes are 101, 110 and 111. Each accepted cycle gives a beat one cycle later, with `re_data_o` = `in_re_i` and `im_data_o` = `in_im_i`, and there is no priming.
- R6: In the single-source codes, the beats after a restart are numbered c = 0, 1, 2 and so on. `win_start_o` is high on beat c exactly when (c mod 2·BLK_LEN) < BLK_LEN and c mod hop = 0. The hop is BLK_LEN for 001 (no overlap), BLK_LEN/2 for 010 (50%), BLK_LEN/4 for 011 (75%) and BLK_LEN/8 for 100 (87.5%).
- R7: In the dual-source codes, `win_start_o` is high on beat c exactly when c mod hop = 0. The hop is BLK_LEN for 101, BLK_LEN/2 for 110 and BLK_LEN/4 for 111.
- R8: A cycle whose mode differs from the previous cycle's mode is a restart. Its sample is dropped, and both the priming and the beat numbering start again.
- R9: A cycle with `in_vld_i` low gives no lane beat one cycle later. It does not advance the delay line or the beat numbering.
- R10: `re_vld_o` and `im_vld_o` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 3 | Source and overlap selection code |
| in_vld_i | input | 1 | Input sample strobe |
| in_re_i | input | DATA_W | Single-source stream, or source A in dual modes |
| in_im_i | input | DATA_W | Source B in dual modes, ignored otherwise |
| re_vld_o | output | 1 | Real lane strobe |
| re_data_o | output | DATA_W | Real lane sample |
| im_vld_o | output | 1 | Imaginary lane strobe |
| im_data_o | output | DATA_W | Imaginary lane sample |
| win_start_o | output | 1 | First beat of a pair window |
| cfg_err_o | output | 1 | Invalid mode code seen |

## Verification
The assertions take for granted that `mode_i` and `in_vld_i` are never unknown after reset, that BLK_LEN is a power of two of at least 8, and that a mode change is meant to restart the stream. The stimulus drives only defined codes and strobes. It changes modes on purpose in the middle of random traffic, with about one cycle in four left idle, so that restarts, bubbles and the priming boundary all happen. In every cycle the bench compares the outputs against its own history of accepted samples.

// File: rtl/bpf_pkg.sv
package bpf_pkg;

  typedef enum logic [1:0] {
    OVL_NONE    = 2'd0,
    OVL_HALF    = 2'd1,
    OVL_QUARTER = 2'd2,
    OVL_EIGHTH  = 2'd3
  } ovl_e;

  typedef struct packed {
    logic ok;
    logic dual;
    ovl_e ovl;
  } feed_cfg_t;

  function automatic feed_cfg_t decode_mode(input logic [2:0] code);
    feed_cfg_t c;
    c.ok   = 1'b1;
    c.dual = 1'b0;
    c.ovl  = OVL_NONE;
    case (code)
      3'b001:  c.ovl = OVL_NONE;
      3'b010:  c.ovl = OVL_HALF;
      3'b011:  c.ovl = OVL_QUARTER;
      3'b100:  c.ovl = OVL_EIGHTH;
      3'b101:  begin c.dual = 1'b1; c.ovl = OVL_NONE;    end
      3'b110:  begin c.dual = 1'b1; c.ovl = OVL_HALF;    end
      3'b111:  begin c.dual = 1'b1; c.ovl = OVL_QUARTER; end
      default: c.ok = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bpf_mode_decode.sv
module bpf_mode_decode
  import bpf_pkg::*;
(
  input  logic [2:0] mode_i,
  output feed_cfg_t  cfg_o
);

  always_comb begin
    cfg_o = decode_mode(mode_i);
  end

endmodule

// File: rtl/bpf_delay_line.sv
module bpf_delay_line #(
  parameter int DATA_W  = 16,
  parameter int BLK_LEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              primed_o
);

  localparam int PW = $clog2(BLK_LEN);
  localparam int FW = $clog2(BLK_LEN + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(BLK_LEN - 1);
  localparam logic [FW-1:0] FILL_MAX = FW'(BLK_LEN);

  logic [DATA_W-1:0] mem_q [BLK_LEN];
  logic [PW-1:0]     wptr_q, wptr_d;
  logic [FW-1:0]     fill_q, fill_d;

  assign dout_o   = mem_q[wptr_q];
  assign primed_o = (fill_q == FILL_MAX);

  always_comb begin
    wptr_d = wptr_q;
    fill_d = fill_q;
    if (clr_i) begin
      wptr_d = '0;
      fill_d = '0;
    end else if (wr_i) begin
      wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
      if (fill_q != FILL_MAX) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i) mem_q[wptr_q] <= din_i;
  end

  assert_fill_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FILL_MAX);

  assert_restart_unprimes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !primed_o);

endmodule

// File: rtl/bpf_window_mark.sv
module bpf_window_mark
  import bpf_pkg::*;
#(
  parameter int BLK_LEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  input  logic dual_i,
  input  ovl_e ovl_i,
  output logic start_o
);

  localparam int CW = $clog2(BLK_LEN) + 1;

  logic [CW-1:0] pos_q, pos_d;
  logic [CW-1:0] hop_mask;

  always_comb begin
    case (ovl_i)
      OVL_HALF:    hop_mask = CW'(BLK_LEN / 2 - 1);
      OVL_QUARTER: hop_mask = CW'(BLK_LEN / 4 - 1);
      OVL_EIGHTH:  hop_mask = CW'(BLK_LEN / 8 - 1);
      default:     hop_mask = CW'(BLK_LEN - 1);
    endcase
  end

  always_comb begin
    start_o = adv_i && ((pos_q & hop_mask) == '0) && (dual_i || !pos_q[CW-1]);
  end

  always_comb begin
    pos_d = pos_q;
    if (clr_i)      pos_d = '0;
    else if (adv_i) pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

endmodule

// File: rtl/bpf_top.sv
module bpf_top
  import bpf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BLK_LEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              in_vld_i,
  input  logic [DATA_W-1:0] in_re_i,
  input  logic [DATA_W-1:0] in_im_i,
  output logic              re_vld_o,
  output logic [DATA_W-1:0] re_data_o,
  output logic              im_vld_o,
  output logic [DATA_W-1:0] im_data_o,
  output logic              win_start_o,
  output logic              cfg_err_o
);

  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  feed_cfg_t         cfg;
  logic [2:0]        mode_q;
  logic              restart, accept, dl_wr, dl_primed, fire, start_c;
  logic [DATA_W-1:0] dl_out;
  logic [DATA_W-1:0] re_d, im_d, re_q, im_q;
  logic              vld_q, start_q, err_q;

  bpf_mode_decode u_dec (
    .mode_i (mode_i),
    .cfg_o  (cfg)
  );

  always_comb begin
    restart = (mode_i != mode_q);
    accept  = in_vld_i && !restart && cfg.ok;
    dl_wr   = accept && !cfg.dual;
    fire    = accept && (cfg.dual || dl_primed);
    re_d    = cfg.dual ? in_re_i : dl_out;
    im_d    = cfg.dual ? in_im_i : in_re_i;
  end

  bpf_delay_line #(
    .DATA_W  (DATA_W),
    .BLK_LEN (BLK_LEN)
  ) u_dly (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .clr_i    (restart),
    .wr_i     (dl_wr),
    .din_i    (in_re_i),
    .dout_o   (dl_out),
    .primed_o (dl_primed)
  );

  bpf_window_mark #(
    .BLK_LEN (BLK_LEN)
  ) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .clr_i   (restart),
    .adv_i   (fire),
    .dual_i  (cfg.dual),
    .ovl_i   (cfg.ovl),
    .start_o (start_c)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      vld_q   <= 1'b0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      mode_q  <= mode_i;
      vld_q   <= fire;
      start_q <= start_c;
      err_q   <= !cfg.ok;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      re_q <= '0;
      im_q <= '0;
    end else if (fire) begin
      re_q <= re_d;
      im_q <= im_d;
    end
  end

  assign re_vld_o    = vld_q;
  assign im_vld_o    = vld_q;
  assign re_data_o   = re_q;
  assign im_data_o   = im_q;
  assign win_start_o = start_q;
  assign cfg_err_o   = err_q;

  assert_err_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_err_o |-> !re_vld_o);

  assert_beat_needs_input_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    re_vld_o |-> $past(in_vld_i));

  assert_start_on_beat_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    win_start_o |-> re_vld_o);

  assert_restart_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_i != $past(mode_i)) |=> !re_vld_o);

endmodule

// File: tb/test_bpf_top.sv
module test_bpf_top;

  localparam int DW = 16;
  localparam int L  = 64;

  logic          clk, rst_n, vld;
  logic [2:0]    mode;
  logic [DW-1:0] re, im;
  logic          re_vld, im_vld, win, err;
  logic [DW-1:0] re_out, im_out;

  int checks, errors;
  bit done;

  logic [DW-1:0] hist [1024];
  logic [2:0]    prev_m;
  int            n_acc, beat;

  bpf_top #(.DATA_W(DW), .BLK_LEN(L)) i_bpf_top (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .in_vld_i(vld),
    .in_re_i(re), .in_im_i(im),
    .re_vld_o(re_vld), .re_data_o(re_out), .im_vld_o(im_vld), .im_data_o(im_out),
    .win_start_o(win), .cfg_err_o(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hop_of(input logic [2:0] m);
    case (m)
      3'd2, 3'd6: return L / 2;
      3'd3, 3'd7: return L / 4;
      3'd4:       return L / 8;
      default:    return L;
    endcase
  endfunction

  function automatic bit start_exp(input logic [2:0] m, input int c);
    if (m >= 3'd5) return (c % hop_of(m)) == 0;
    return ((c % (2 * L)) < L) && ((c % hop_of(m)) == 0);
  endfunction

  task automatic step(input logic [2:0] m, input logic v, input logic [DW-1:0] r,
                      input logic [DW-1:0] i);
    bit e_vld, e_st, restart;
    logic [DW-1:0] e_re, e_im;
    string tv;
    e_vld = 1'b0; e_st = 1'b0; e_re = '0; e_im = '0;
    @(negedge clk);
    mode = m; vld = v; re = r; im = i;
    restart = (m != prev_m);
    prev_m  = m;
    tv = (m >= 3'd5) ? "R5" : "R4";
    if (restart) begin
      n_acc = 0; beat = 0; tv = "R8";
    end else if (m == 3'd0) begin
      tv = "R2";
    end else if (!v) begin
      tv = "R9";
    end else if (m >= 3'd5) begin
      e_vld = 1'b1; e_re = r; e_im = i; e_st = start_exp(m, beat);
      beat++; n_acc++;
    end else begin
      if (n_acc >= L) begin
        e_vld = 1'b1; e_re = hist[(n_acc - L) % 1024]; e_im = r;
        e_st = start_exp(m, beat);
        beat++;
      end
      hist[n_acc % 1024] = r;
      n_acc++;
    end
    @(posedge clk);
    #1;
    check(re_vld == e_vld, tv, int'(re_vld), int'(e_vld));
    check(re_vld == im_vld, "R10", int'(im_vld), int'(re_vld));
    check(err == (m == 3'd0), "R2", int'(err), int'(m == 3'd0));
    if (e_vld) begin
      if (m >= 3'd5) begin
        check(re_out == e_re, "R5 real", int'(re_out), int'(e_re));
        check(im_out == e_im, "R5 imag", int'(im_out), int'(e_im));
        check(win == e_st, "R7", int'(win), int'(e_st));
      end else begin
        check(re_out == e_re, "R3 real", int'(re_out), int'(e_re));
        check(im_out == e_im, "R3 imag", int'(im_out), int'(e_im));
        check(win == e_st, "R6", int'(win), int'(e_st));
      end
    end else begin
      check(win == 1'b0, "R6 idle", int'(win), 0);
    end
  endtask

  task automatic run_random(input logic [2:0] m, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(m, v, DW'($urandom), DW'($urandom));
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    prev_m = 3'd0; n_acc = 0; beat = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mode = 3'd0; vld = 1'b0; re = '0; im = '0;
    repeat (3) @(posedge clk);
    #1;
    check({re_vld, im_vld, win, err} == 4'b0, "R1", int'({re_vld, im_vld, win, err}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    run_random(3'd0, 20);
    // R4 directed: exactly L valid samples, then one more which is the first beat
    for (int k = 0; k < L + 4; k++) step(3'd1, 1'b1, DW'(k + 100), DW'(0));
    run_random(3'd1, 300);
    run_random(3'd2, 400);
    run_random(3'd3, 400);
    run_random(3'd4, 400);
    // R9 directed: long idle gap inside a primed stream
    for (int k = 0; k < 10; k++) step(3'd4, 1'b0, '0, '0);
    run_random(3'd4, 100);
    run_random(3'd5, 300);
    run_random(3'd6, 300);
    run_random(3'd7, 300);
    run_random(3'd0, 10);
    run_random(3'd2, 300);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule